// File: doc/BRIEF.md
# Processor Status Register with Protected Bits

This block holds the eight-bit status word of a small accumulator-style processor core. It keeps three arithmetic flags (zero, digit carry, carry), two bits that record why the core last restarted or stopped (timeout and power-down), and the data-memory bank select. The decoder presents a data write when an instruction names the status word as its destination. The ALU presents a per-flag update mask with the new flag values. The power and watchdog logic presents single-cycle event pulses.

Each bit of a data write is masked separately. The arithmetic flags refuse the written value whenever the same instruction also updates flags. The timeout and power-down bits cannot be written at all and respond only to events. The bank select bits are joined with the instruction's seven-bit direct address to form a nine-bit data-memory address.

Top module: `psr_top`

## Requirements
- R1: While `rst_n` is low at a clock edge, bits 7:5 become 0 and bits 4 (timeout) and 3 (power-down) become 1. Bits 2:0 are left unreset.
- R2: A data write (`wr_en`=1) with `alu_we`=0 loads bits 7:5 and bits 2:0 from `wr_data` at the next edge.
- R3: A data write never changes bit 4 or bit 3, whatever `wr_data` holds.
- R4: When `wr_en`=1 and any bit of `alu_we` is 1, bits 2:0 ignore `wr_data`. Each flag whose `alu_we` bit is 1 takes `alu_flags`, the others hold, and bits 7:5 are still written. A clearing write that sets only zero gives 000uu1uu.
- R5: With `wr_en`=0, each flag whose `alu_we` bit is 1 takes the matching `alu_flags` bit (index 2 = zero, 1 = digit carry, 0 = carry).
- R6: Timeout (bit 4) becomes 1 on `ev_pwrup`, `ev_wdt_clr` or `ev_sleep`, and becomes 0 on `ev_wdt_tmo`. Any setting event in the same cycle wins over a timeout.
- R7: Power-down (bit 3) becomes 1 on `ev_pwrup` or `ev_wdt_clr`, and becomes 0 on `ev_sleep`. The setting events win over sleep.
- R8: `mem_addr` is {bit 6, bit 5, `dir_addr`} without delay, so bank code 0..3 selects byte range n*128 .. n*128+127.
- R9: `rd_data` shows the stored word with layout [7] spare bank bit, [6:5] bank select, [4] timeout, [3] power-down, [2] zero, [1] digit carry, [0] carry. Bits 7 and 6 read back exactly as written.
- R10: In a cycle with no event, bits 4 and 3 hold their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Data write to the status word |
| wr_data | input | 8 | Value of the data write |
| alu_we | input | 3 | Per-flag update mask from the ALU (zero, digit carry, carry) |
| alu_flags | input | 3 | New flag values from the ALU |
| ev_pwrup | input | 1 | Power-up event pulse |
| ev_wdt_clr | input | 1 | Watchdog-clear instruction pulse |
| ev_sleep | input | 1 | Sleep instruction pulse |
| ev_wdt_tmo | input | 1 | Watchdog timeout pulse |
| dir_addr | input | 7 | Direct address field of the instruction |
| rd_data | output | 8 | Current status word |
| mem_addr | output | 9 | Banked data-memory address |

## Verification
The assertions take each event input to be a pulse that the core logic qualifies. They allow any mix of events in one cycle and rely on the stated priorities. The assertions also take `alu_we` as meaningful with or without a data write. Because the flags have no reset value, the stimulus writes them before any check compares them. The bench model masks them as unknown until then. The stimulus covers colliding events (clear with timeout, sleep with timeout), a partial ALU mask, a write that tries to set the protected bits, and all four bank codes.

// File: rtl/psr_pkg.sv
// Package: field positions and widths of the status word.
// Assumes the fixed eight-bit layout; the core decoder relies on these positions.
package psr_pkg;
    localparam int unsigned PSR_W   = 8;
    localparam int unsigned FLAG_W  = 3;
    localparam int unsigned BIT_C   = 0;
    localparam int unsigned BIT_DC  = 1;
    localparam int unsigned BIT_Z   = 2;
    localparam int unsigned BIT_PD  = 3;
    localparam int unsigned BIT_TO  = 4;
    localparam int unsigned BIT_BK0 = 5;
    localparam int unsigned UPPER_W = PSR_W - BIT_BK0;

    typedef struct packed {
        logic [UPPER_W-1:0] upper;
        logic               to_b;
        logic               pd_b;
        logic [FLAG_W-1:0]  flags;
    } psr_t;
endpackage

// File: rtl/psr_flag_unit.sv
// Flag unit: stores zero, digit carry and carry.
// Each flag takes the ALU value when its mask bit is set. Otherwise it takes the data
// write, but only when no flag is updated in the same cycle. Flags have no reset on purpose.
module psr_flag_unit #(
    parameter int unsigned FLAG_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [FLAG_W-1:0] wr_flags,
    input  logic [FLAG_W-1:0] alu_we,
    input  logic [FLAG_W-1:0] alu_flags,
    output logic [FLAG_W-1:0] flags_q
);
    logic wr_allowed;

    // Purpose: a data write reaches the flags only when the ALU leaves them alone.
    always_comb wr_allowed = wr_en && (alu_we == '0);

    for (genvar i = 0; i < FLAG_W; i++) begin : g_flag
        // Purpose: one flag bit, with ALU priority over the data write.
        always_ff @(posedge clk) begin
            if (alu_we[i])       flags_q[i] <= alu_flags[i];
            else if (wr_allowed) flags_q[i] <= wr_flags[i];
        end

        // R4: an unmasked flag holds while the ALU updates other flags.
        p_unmasked_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && alu_we != '0 && !alu_we[i]) |=> $stable(flags_q[i]));
    end

    // R2: a plain data write lands in the flags.
    p_plain_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && alu_we == '0) |=> flags_q == $past(wr_flags));
endmodule

// File: rtl/psr_cause_unit.sv
// Cause unit: timeout and power-down bits, driven only by events.
// Assumes single-cycle event pulses; any mix of events in one cycle is allowed.
module psr_cause_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic ev_pwrup,
    input  logic ev_wdt_clr,
    input  logic ev_sleep,
    input  logic ev_wdt_tmo,
    output logic to_q,
    output logic pd_q
);
    logic to_set, pd_set;

    // Purpose: group the events that raise each bit.
    always_comb begin
        pd_set = ev_pwrup | ev_wdt_clr;
        to_set = pd_set | ev_sleep;
    end

    // Purpose: timeout bit; a setting event beats a watchdog timeout.
    always_ff @(posedge clk) begin
        if (!rst_n)          to_q <= 1'b1;
        else if (to_set)     to_q <= 1'b1;
        else if (ev_wdt_tmo) to_q <= 1'b0;
    end

    // Purpose: power-down bit; power-up or clear beats sleep.
    always_ff @(posedge clk) begin
        if (!rst_n)        pd_q <= 1'b1;
        else if (pd_set)   pd_q <= 1'b1;
        else if (ev_sleep) pd_q <= 1'b0;
    end

    // R1: reset raises both cause bits.
    p_reset_cause_r1: assert property (@(posedge clk)
        !rst_n |=> (to_q && pd_q));
    // R6: a watchdog clear always leaves timeout at 1.
    p_clear_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ev_wdt_clr |=> to_q);
    // R7: sleep alone drops power-down.
    p_sleep_pd_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_sleep && !ev_pwrup && !ev_wdt_clr) |=> !pd_q);
    // R10: with no event, both cause bits hold.
    p_cause_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_pwrup || ev_wdt_clr || ev_sleep || ev_wdt_tmo) |=> $stable({to_q, pd_q}));
endmodule

// File: rtl/psr_bank_unit.sv
// Bank unit: spare bit and bank select, written only by data writes.
// It also forms the banked data-memory address. Assumes the bank code sits in the low bits.
module psr_bank_unit #(
    parameter int unsigned UPPER_W = 3,
    parameter int unsigned BANK_W  = 2,
    parameter int unsigned DIR_AW  = 7,
    localparam int unsigned MEM_AW = DIR_AW + BANK_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [UPPER_W-1:0] wr_upper,
    input  logic [DIR_AW-1:0]  dir_addr,
    output logic [UPPER_W-1:0] upper_q,
    output logic [MEM_AW-1:0]  mem_addr
);
    // Purpose: store the upper bits exactly as written.
    always_ff @(posedge clk) begin
        if (!rst_n)     upper_q <= '0;
        else if (wr_en) upper_q <= wr_upper;
    end

    // Purpose: prepend the bank code to the direct address.
    always_comb mem_addr = {upper_q[BANK_W-1:0], dir_addr};

    // R1: reset clears the upper bits.
    p_reset_upper_r1: assert property (@(posedge clk)
        !rst_n |=> upper_q == '0);
    // R2: a write is stored unchanged.
    p_upper_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> upper_q == $past(wr_upper));
endmodule

// File: rtl/psr_top.sv
// Top: status word with per-bit write protection.
// Joins the flag, cause and bank units. Assumes the decoder and ALU sit outside.
module psr_top #(
    parameter int unsigned DIR_AW = 7,
    parameter int unsigned BANK_W = 2,
    localparam int unsigned MEM_AW = DIR_AW + BANK_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       wr_en,
    input  logic [psr_pkg::PSR_W-1:0]  wr_data,
    input  logic [psr_pkg::FLAG_W-1:0] alu_we,
    input  logic [psr_pkg::FLAG_W-1:0] alu_flags,
    input  logic                       ev_pwrup,
    input  logic                       ev_wdt_clr,
    input  logic                       ev_sleep,
    input  logic                       ev_wdt_tmo,
    input  logic [DIR_AW-1:0]          dir_addr,
    output logic [psr_pkg::PSR_W-1:0]  rd_data,
    output logic [MEM_AW-1:0]          mem_addr
);
    import psr_pkg::*;

    psr_t wr_view, cur;

    // Purpose: view the written byte through the field layout.
    always_comb wr_view = psr_t'(wr_data);

    psr_flag_unit #(.FLAG_W(FLAG_W)) u_flags (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_flags(wr_view.flags),
        .alu_we(alu_we), .alu_flags(alu_flags), .flags_q(cur.flags)
    );

    psr_cause_unit u_cause (
        .clk(clk), .rst_n(rst_n), .ev_pwrup(ev_pwrup), .ev_wdt_clr(ev_wdt_clr),
        .ev_sleep(ev_sleep), .ev_wdt_tmo(ev_wdt_tmo), .to_q(cur.to_b), .pd_q(cur.pd_b)
    );

    psr_bank_unit #(.UPPER_W(UPPER_W), .BANK_W(BANK_W), .DIR_AW(DIR_AW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_upper(wr_view.upper),
        .dir_addr(dir_addr), .upper_q(cur.upper), .mem_addr(mem_addr)
    );

    // Purpose: present the stored word for reads.
    always_comb rd_data = cur;

    // R3: a data write with no event leaves the cause bits alone.
    p_protect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !(ev_pwrup || ev_wdt_clr || ev_sleep || ev_wdt_tmo))
        |=> $stable(rd_data[BIT_TO:BIT_PD]));
endmodule

// File: tb/psr_top_tb_top.sv
// Scoreboard bench: the driver pushes expected words, the monitor pops and compares them.
module psr_top_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic [2:0] alu_we = '0, alu_flags = '0;
    logic ev_pwrup = 0, ev_wdt_clr = 0, ev_sleep = 0, ev_wdt_tmo = 0;
    logic [6:0] dir_addr = '0;
    logic [7:0] rd_data;
    logic [8:0] mem_addr;

    int checks = 0;
    int errors = 0;
    logic [7:0] m_v = '0;
    logic [7:0] m_known = '0;
    logic [7:0] qv[$];
    logic [7:0] qm[$];
    string      qt[$];

    always #4 clk = ~clk;

    psr_top dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .alu_we(alu_we), .alu_flags(alu_flags), .ev_pwrup(ev_pwrup),
        .ev_wdt_clr(ev_wdt_clr), .ev_sleep(ev_sleep), .ev_wdt_tmo(ev_wdt_tmo),
        .dir_addr(dir_addr), .rd_data(rd_data), .mem_addr(mem_addr)
    );

    // Monitor: compare the registered word after each edge.
    always @(posedge clk) begin : mon
        logic [7:0] ev, em;
        string et;
        #2;
        if (qv.size() > 0) begin
            ev = qv.pop_front();
            em = qm.pop_front();
            et = qt.pop_front();
            checks++;
            if ((rd_data & em) !== (ev & em)) begin
                errors++;
                $display("FAIL %s: rd_data=%h expected=%h (mask %h)", et, rd_data, ev, em);
            end
        end
    end

    task automatic push(string tag);
        qv.push_back(m_v);
        qm.push_back(m_known);
        qt.push_back(tag);
    endtask

    task automatic do_reset(string tag);
        @(negedge clk);
        rst_n = 1'b0; wr_en = 0; alu_we = '0;
        {ev_pwrup, ev_wdt_clr, ev_sleep, ev_wdt_tmo} = '0;
        m_v[7:3] = 5'b00011;
        m_known = m_known | 8'hF8;
        push(tag);
    endtask

    // Driver: apply one cycle of stimulus and predict the word after the edge.
    task automatic step(bit wr, logic [7:0] wd, logic [2:0] awe, logic [2:0] af,
                        bit pu, bit clr, bit slp, bit tmo, string tag);
        logic [7:0] nx;
        @(negedge clk);
        rst_n = 1'b1; wr_en = wr; wr_data = wd; alu_we = awe; alu_flags = af;
        ev_pwrup = pu; ev_wdt_clr = clr; ev_sleep = slp; ev_wdt_tmo = tmo;
        nx = m_v;
        if (wr) nx[7:5] = wd[7:5];
        for (int i = 0; i < 3; i++) begin
            if (awe[i]) begin
                nx[i] = af[i]; m_known[i] = 1'b1;
            end else if (wr && awe == 3'b000) begin
                nx[i] = wd[i]; m_known[i] = 1'b1;
            end
        end
        if (pu || clr || slp) nx[4] = 1'b1;
        else if (tmo)         nx[4] = 1'b0;
        if (pu || clr)        nx[3] = 1'b1;
        else if (slp)         nx[3] = 1'b0;
        m_v = nx;
        push(tag);
    endtask

    task automatic addr_chk(logic [6:0] da, string tag);
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, 0, tag);
        dir_addr = da;
        #1;
        checks++;
        if (mem_addr !== {m_v_prev_bank, da}) begin
            errors++;
            $display("FAIL %s: mem_addr=%h expected=%h", tag, mem_addr, {m_v_prev_bank, da});
        end
    endtask

    // Bank code stored before the idle cycle in addr_chk (unchanged by it).
    logic [1:0] m_v_prev_bank;
    always_comb m_v_prev_bank = m_v[6:5];

    initial begin : wdog
        repeat (5000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish, actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        do_reset("R1 reset");
        do_reset("R1 reset hold");
        step(1, 8'hFF, 3'b000, 3'b000, 0, 0, 0, 0, "R2 write all ones");
        step(1, 8'h00, 3'b000, 3'b000, 0, 0, 0, 0, "R3 write zero keeps TO/PD");
        step(1, 8'hA5, 3'b000, 3'b000, 0, 0, 0, 0, "R9 bits 7/6 read back");
        step(0, 8'hFF, 3'b111, 3'b010, 0, 0, 0, 0, "R5 ALU sets all flags");
        step(1, 8'h00, 3'b100, 3'b100, 0, 0, 0, 0, "R4 clear gives 000uu1uu");
        step(1, 8'h07, 3'b001, 3'b000, 0, 0, 0, 0, "R4 partial mask");
        step(0, 8'h00, 3'b010, 3'b000, 0, 0, 0, 0, "R5 ALU digit carry only");
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 1, 0, "R7 sleep drops PD, R6 TO set");
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, 1, "R6 timeout clears TO");
        step(1, 8'h18, 3'b000, 3'b000, 0, 0, 0, 0, "R3 write cannot set TO/PD");
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, 0, "R10 idle holds");
        step(0, 8'h00, 3'b000, 3'b000, 0, 1, 0, 1, "R6 clear beats timeout");
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, 1, "R6 timeout again");
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 1, 1, "R6 sleep beats timeout");
        step(0, 8'h00, 3'b000, 3'b000, 1, 0, 1, 0, "R7 power-up beats sleep");
        step(1, 8'hE7, 3'b000, 3'b000, 0, 0, 1, 0, "R3 write with sleep");
        for (int b = 0; b < 4; b++) begin
            step(1, {1'b0, b[1:0], 5'b00000}, 3'b000, 3'b000, 0, 0, 0, 0, "R2 bank write");
            addr_chk(7'h5A + 7'(b), "R8 banked address");
        end
        step(0, 8'h00, 3'b000, 3'b000, 0, 0, 0, 0, "R10 final idle");
        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule